// File: doc/BRIEF.md
# Chained DMA Descriptor Sequencer

This block is a single-channel memory-to-memory copy engine. It follows a linked list of command descriptors stored in memory. Software fills eight channel registers through a small write port and pulses `start`. If the chain register is non-zero, the engine first fetches the descriptor it points to. Either way, it then copies `count` words. Each word is read from the source address and written to the destination address, and both addresses move by signed byte increments after every word. When the count reaches zero, the engine fetches the next descriptor from the chain register and carries on. It stops when that register holds zero.

Each descriptor is eight 32-bit words, and their order matches the register indices. The control register selects how a descriptor is fetched. In compact mode only the link, the two addresses and the count are fetched. In full mode the increments, control and status are also replaced from memory. Descriptor reads are burst reads that never cross a 32-word-aligned boundary; a descriptor that straddles one is fetched in two bursts. An error response from memory marks the status register and halts the engine on the spot.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low and all eight registers read back as zero.
- R2: Register indices are: 0 link, 1 source, 2 destination, 3 count, 4 source step, 5 destination step, 6 control, 7 status. A write on the config port while idle updates the indexed register, `cfg_rdata` returns register `cfg_raddr` combinationally, and config writes made while `busy` is high are ignored.
- R3: On `start`, a non-zero link register makes the engine fetch the descriptor at that address before any data beat; a zero link register makes it copy directly with the programmed registers.
- R4: With control bit 0 clear, a fetch reads eight words and writes word i into register i, including the status register.
- R5: With control bit 0 set, a fetch reads only words 0 to 3, and registers 4 to 7 keep their values. The mode is taken from the control register in force when each fetch begins.
- R6: A descriptor fetch is issued as read bursts that never cross a 32-word-aligned boundary: a single burst when the descriptor fits, otherwise one burst up to the boundary and one burst after it.
- R7: Each data beat is a one-word read at the source address followed by a one-word write of that data to the destination address. After the beat, source and destination advance by their step registers (two's-complement byte offsets) and the count drops by one.
- R8: A descriptor whose count is zero causes no data beats.
- R9: When the count is zero and the link is non-zero, the next descriptor is fetched without software action. When the link is zero, the engine stops: `done` is high for exactly one cycle, and in that same cycle `busy` goes low.
- R10: `busy` is high from the cycle after `start` until the engine stops, and no memory request is made while it is low.
- R11: A response with `mem_err` set sets status bit 0, drops `busy` in the next cycle without pulsing `done`, and no further request is issued.
- R12: A request holds its address, direction and length stable until `mem_gnt`. Writes always carry length 1, and every request receives exactly `mem_len` responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write index |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register read index |
| cfg_rdata | output | 32 | Register read data |
| start | input | 1 | Start pulse, taken while idle |
| busy | output | 1 | Engine running |
| done | output | 1 | One-cycle end-of-chain pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_len | output | 4 | Number of beats in the request |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Response beat valid |
| mem_rdata | input | 32 | Response read data |
| mem_err | input | 1 | Response beat carries an error |

## Verification
The copy path is tried with several kinds of run:
- a direct copy with no link, which separates the direct start from a start that fetches first;
- a three-descriptor full-mode chain with a negative source step and a zero-count tail, which shows whether status is overwritten and whether empty descriptors are skipped;
- a compact chain whose unused descriptor words hold junk, which exposes any over-fetch;
- descriptors at word offsets 28, 30 and 31 of a 32-word block, which give splits of 4+4, 2+6 and 1+3 and a full-to-compact mode change partway through the chain.

Error responses are injected on a data read and on the third beat of a fetch. These show whether the engine halts at the right beat or follows the chain anyway. A config write made mid-run shows whether idle-only programming is enforced.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam int REG_N    = 8;
    localparam int IDX_LINK = 0;
    localparam int IDX_SRC  = 1;
    localparam int IDX_DST  = 2;
    localparam int IDX_CNT  = 3;
    localparam int IDX_SSTP = 4;
    localparam int IDX_DSTP = 5;
    localparam int IDX_CTL  = 6;
    localparam int IDX_STS  = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FREQ,
        S_FWAIT,
        S_XCHK,
        S_RREQ,
        S_RWAIT,
        S_WREQ,
        S_WWAIT
    } seq_state_e;

endpackage

// File: rtl/dma_chain_burst.sv
// Length of the next descriptor burst: the words still needed, capped at
// the room left before the next aligned boundary.
module dma_chain_burst #(
    parameter int BOUND_WORDS = 32,
    parameter int LEN_W       = 4,
    localparam int BND_LOG2   = $clog2(BOUND_WORDS)
) (
    input  logic [BND_LOG2-1:0] word_off,
    input  logic [LEN_W-1:0]    need,
    output logic [LEN_W-1:0]    len
);
    int unsigned room;
    int unsigned need_i;

    always_comb begin
        room   = BOUND_WORDS - int'(word_off);
        need_i = int'(need);
        if (need_i < room) begin
            len = need;
        end else begin
            len = LEN_W'(room);
        end
    end
endmodule

// File: rtl/dma_chain_regs.sv
// Channel register file: one write port shared by the config side and the
// descriptor fetch, a per-beat pointer step, and an error flag set.
module dma_chain_regs
    import dma_chain_pkg::*;
#(
    parameter int DW      = 32,
    parameter int IDX_W   = 3,
    parameter int ERR_BIT = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          idx,
    input  logic [DW-1:0]             wdata,
    input  logic                      step,
    input  logic                      err_set,
    output logic [REG_N-1:0][DW-1:0]  regs_o
);
    typedef struct packed {
        logic [REG_N-1:0][DW-1:0] r;
    } rf_t;

    rf_t rf_q, rf_d;

    always_comb begin
        rf_d = rf_q;
        if (we) begin
            rf_d.r[idx] = wdata;
        end else if (step) begin
            rf_d.r[IDX_SRC] = rf_q.r[IDX_SRC] + rf_q.r[IDX_SSTP];
            rf_d.r[IDX_DST] = rf_q.r[IDX_DST] + rf_q.r[IDX_DSTP];
            rf_d.r[IDX_CNT] = rf_q.r[IDX_CNT] - DW'(1);
        end
        if (err_set) begin
            rf_d.r[IDX_STS][ERR_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign regs_o = rf_q.r;
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dma_chain_pkg::*;
#(
    parameter int DW            = 32,
    parameter int BOUND_WORDS   = 32,
    parameter int COMPACT_WORDS = 4,
    parameter int COMPACT_BIT   = 0,
    parameter int ERR_BIT       = 0,
    localparam int FULL_WORDS   = REG_N,
    localparam int IDX_W        = $clog2(FULL_WORDS),
    localparam int LEN_W        = $clog2(FULL_WORDS) + 1,
    localparam int BND_LOG2     = $clog2(BOUND_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic [IDX_W-1:0] cfg_raddr,
    output logic [DW-1:0]    cfg_rdata,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [DW-1:0]    mem_addr,
    output logic [LEN_W-1:0] mem_len,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_gnt,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_err
);
    typedef struct packed {
        seq_state_e       state;
        logic [DW-1:0]    fbase;
        logic [LEN_W-1:0] fidx;
        logic [LEN_W-1:0] beats;
        logic [LEN_W-1:0] nwords;
        logic [DW-1:0]    data;
        logic             done;
    } ctx_t;

    ctx_t q, d;

    logic [REG_N-1:0][DW-1:0] regs;
    logic                     rf_we;
    logic [IDX_W-1:0]         rf_idx;
    logic [DW-1:0]            rf_wd;
    logic                     rf_step;
    logic                     rf_err;

    logic [DW-1:0]    fetch_addr;
    logic [LEN_W-1:0] fetch_need;
    logic [LEN_W-1:0] fetch_len;
    logic [LEN_W-1:0] fidx_nxt;
    logic [LEN_W-1:0] mode_words;
    logic             link_nz;

    assign link_nz    = (regs[IDX_LINK] != '0);
    assign mode_words = regs[IDX_CTL][COMPACT_BIT] ? LEN_W'(COMPACT_WORDS)
                                                   : LEN_W'(FULL_WORDS);
    assign fetch_addr = q.fbase + DW'({q.fidx, 2'b00});
    assign fetch_need = q.nwords - q.fidx;
    assign fidx_nxt   = q.fidx + LEN_W'(1);

    dma_chain_burst #(
        .BOUND_WORDS(BOUND_WORDS),
        .LEN_W      (LEN_W)
    ) burst_i (
        .word_off(fetch_addr[2 +: BND_LOG2]),
        .need    (fetch_need),
        .len     (fetch_len)
    );

    dma_chain_regs #(
        .DW     (DW),
        .IDX_W  (IDX_W),
        .ERR_BIT(ERR_BIT)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rf_we),
        .idx    (rf_idx),
        .wdata  (rf_wd),
        .step   (rf_step),
        .err_set(rf_err),
        .regs_o (regs)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        rf_we   = 1'b0;
        rf_idx  = cfg_addr;
        rf_wd   = cfg_wdata;
        rf_step = 1'b0;
        rf_err  = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                rf_we = cfg_we;
                if (start) begin
                    if (link_nz) begin
                        d.state  = S_FREQ;
                        d.fbase  = regs[IDX_LINK];
                        d.fidx   = '0;
                        d.nwords = mode_words;
                    end else begin
                        d.state = S_XCHK;
                    end
                end
            end
            S_FREQ: begin
                if (mem_gnt) begin
                    d.beats = fetch_len;
                    d.state = S_FWAIT;
                end
            end
            S_FWAIT: begin
                if (mem_rvalid) begin
                    if (mem_err) begin
                        rf_err  = 1'b1;
                        d.state = S_IDLE;
                    end else begin
                        rf_we   = 1'b1;
                        rf_idx  = q.fidx[IDX_W-1:0];
                        rf_wd   = mem_rdata;
                        d.fidx  = fidx_nxt;
                        d.beats = q.beats - LEN_W'(1);
                        if (fidx_nxt == q.nwords) begin
                            d.state = S_XCHK;
                        end else if (q.beats == LEN_W'(1)) begin
                            d.state = S_FREQ;
                        end
                    end
                end
            end
            S_XCHK: begin
                if (regs[IDX_CNT] == '0) begin
                    if (link_nz) begin
                        d.state  = S_FREQ;
                        d.fbase  = regs[IDX_LINK];
                        d.fidx   = '0;
                        d.nwords = mode_words;
                    end else begin
                        d.state = S_IDLE;
                        d.done  = 1'b1;
                    end
                end else begin
                    d.state = S_RREQ;
                end
            end
            S_RREQ: begin
                if (mem_gnt) begin
                    d.state = S_RWAIT;
                end
            end
            S_RWAIT: begin
                if (mem_rvalid) begin
                    if (mem_err) begin
                        rf_err  = 1'b1;
                        d.state = S_IDLE;
                    end else begin
                        d.data  = mem_rdata;
                        d.state = S_WREQ;
                    end
                end
            end
            S_WREQ: begin
                if (mem_gnt) begin
                    d.state = S_WWAIT;
                end
            end
            S_WWAIT: begin
                if (mem_rvalid) begin
                    if (mem_err) begin
                        rf_err  = 1'b1;
                        d.state = S_IDLE;
                    end else begin
                        rf_step = 1'b1;
                        d.state = S_XCHK;
                    end
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.state != S_IDLE);
    assign done      = q.done;
    assign mem_req   = (q.state == S_FREQ) || (q.state == S_RREQ) || (q.state == S_WREQ);
    assign mem_we    = (q.state == S_WREQ);
    assign mem_wdata = (q.state == S_WREQ) ? q.data : '0;
    assign cfg_rdata = regs[cfg_raddr];

    always_comb begin
        unique case (q.state)
            S_FREQ: begin
                mem_addr = fetch_addr;
                mem_len  = fetch_len;
            end
            S_RREQ: begin
                mem_addr = regs[IDX_SRC];
                mem_len  = LEN_W'(1);
            end
            S_WREQ: begin
                mem_addr = regs[IDX_DST];
                mem_len  = LEN_W'(1);
            end
            default: begin
                mem_addr = '0;
                mem_len  = '0;
            end
        endcase
    end
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
    parameter int DW          = 32,
    parameter int LEN_W       = 4,
    parameter int BOUND_WORDS = 32,
    localparam int BND_LOG2   = $clog2(BOUND_WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             mem_req,
    input logic             mem_gnt,
    input logic             mem_we,
    input logic [DW-1:0]    mem_addr,
    input logic [LEN_W-1:0] mem_len,
    input logic             mem_rvalid,
    input logic             mem_err
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_len)); // R12
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_len == LEN_W'(1)); // R12
    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> (mem_len != '0) && (int'(mem_addr[2 +: BND_LOG2]) + int'(mem_len) <= BOUND_WORDS)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R10
    AST_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && mem_rvalid && mem_err |=> !busy && !done); // R11
endmodule

bind dma_chain_seq dma_chain_seq_chk #(
    .DW         (DW),
    .LEN_W      (LEN_W),
    .BOUND_WORDS(BOUND_WORDS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_len   (mem_len),
    .mem_rvalid(mem_rvalid),
    .mem_err   (mem_err)
);

// File: tb/dma_chain_seq_tb_top.sv
module dma_chain_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  cfg_raddr = '0;
    logic [31:0] cfg_rdata;
    logic        start = 1'b0;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_len;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;

    always #5 clk = ~clk;

    dma_chain_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .start(start), .busy(busy), .done(done), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int done_seen = 0;
    logic [31:0] err_addr = '0;

    logic [31:0] mem       [int unsigned];
    logic [31:0] model_mem [int unsigned];
    logic [31:0] mr [8];
    logic [31:0] eq_addr [$];
    bit          eq_we   [$];
    int          eq_len  [$];
    logic [31:0] eq_wd   [$];
    logic [31:0] rs_data [$];
    bit          rs_err  [$];

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return model_mem.exists(a) ? model_mem[a] : 32'h0;
    endfunction

    task automatic push_txn(input logic [31:0] a, input bit we, input int len, input logic [31:0] wd);
        eq_addr.push_back(a);
        eq_we.push_back(we);
        eq_len.push_back(len);
        eq_wd.push_back(wd);
    endtask

    // Behavioural reference: the sequence of memory requests, final registers, final memory.
    task automatic model_run(input logic [31:0] pr[8], output bit exp_done);
        logic [31:0] r[8];
        logic [31:0] base, a, dv;
        bit halt;
        int nw, i, len, room;
        halt = 1'b0;
        model_mem = mem;
        eq_addr.delete(); eq_we.delete(); eq_len.delete(); eq_wd.delete();
        r = pr;
        if (r[0] != 0) begin
            forever begin
                base = r[0];
                nw = r[6][0] ? 4 : 8;
                i = 0;
                while (i < nw && !halt) begin
                    a = base + 32'(4 * i);
                    room = 32 - (int'(a >> 2) % 32);
                    len = (nw - i < room) ? nw - i : room;
                    push_txn(a, 1'b0, len, 32'h0);
                    for (int k = 0; k < len; k++) begin
                        if (a + 32'(4 * k) == err_addr) begin
                            r[7][0] = 1'b1;
                            halt = 1'b1;
                            break;
                        end
                        r[i + k] = mrd(a + 32'(4 * k));
                    end
                    i += len;
                end
                if (halt) break;
                while (r[3] != 0) begin
                    push_txn(r[1], 1'b0, 1, 32'h0);
                    if (r[1] == err_addr) begin r[7][0] = 1'b1; halt = 1'b1; break; end
                    dv = mrd(r[1]);
                    push_txn(r[2], 1'b1, 1, dv);
                    if (r[2] == err_addr) begin r[7][0] = 1'b1; halt = 1'b1; break; end
                    model_mem[r[2]] = dv;
                    r[1] = r[1] + r[4];
                    r[2] = r[2] + r[5];
                    r[3] = r[3] - 1;
                end
                if (halt || r[0] == 0) break;
            end
        end else begin
            while (r[3] != 0) begin
                push_txn(r[1], 1'b0, 1, 32'h0);
                if (r[1] == err_addr) begin r[7][0] = 1'b1; halt = 1'b1; break; end
                dv = mrd(r[1]);
                push_txn(r[2], 1'b1, 1, dv);
                if (r[2] == err_addr) begin r[7][0] = 1'b1; halt = 1'b1; break; end
                model_mem[r[2]] = dv;
                r[1] = r[1] + r[4];
                r[2] = r[2] + r[5];
                r[3] = r[3] - 1;
            end
        end
        mr = r;
        exp_done = !halt;
    endtask

    // Memory responder and per-clock comparison against the expected request stream.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++;
                $display("FAIL R10 watchdog act=running exp=stopped");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
            if (rs_data.size() > 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = rs_data.pop_front();
                mem_err    = rs_err.pop_front();
            end else begin
                mem_rvalid = 1'b0;
                mem_rdata  = '0;
                mem_err    = 1'b0;
            end
            if (done) begin
                done_seen++;
                if (eq_addr.size() != 0) chk("R9", "done with requests outstanding", 32'(eq_addr.size()), 32'h0);
            end
            if (rst_n && mem_req && (cyc % 3) != 0) begin
                mem_gnt = 1'b1;
                if (eq_addr.size() == 0) begin
                    chk("R12", "unexpected request", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    chk(eq_we[0] ? "R7" : "R6", "req addr", mem_addr, eq_addr.pop_front());
                    chk(eq_we[0] ? "R7" : "R6", "req dir", 32'(mem_we), 32'(eq_we.pop_front()));
                    chk("R6", "req len", 32'(mem_len), 32'(eq_len.pop_front()));
                    chk("R7", "req wdata", mem_we ? mem_wdata : 32'h0, eq_wd.pop_front());
                end
                if (mem_we) begin
                    rs_data.push_back(32'h0);
                    rs_err.push_back(mem_addr == err_addr);
                    if (mem_addr != err_addr) mem[mem_addr] = mem_wdata;
                end else begin
                    for (int k = 0; k < int'(mem_len); k++) begin
                        rs_data.push_back(rd(mem_addr + 32'(4 * k)));
                        rs_err.push_back(mem_addr + 32'(4 * k) == err_addr);
                    end
                end
            end else begin
                mem_gnt = 1'b0;
            end
        end
    end

    task automatic cfg_write(input int idx, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(idx); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run(input string reg_tag, input logic [31:0] pr[8], input logic [31:0] eaddr, input bit poke);
        bit exp_done;
        err_addr = eaddr;
        for (int i = 0; i < 8; i++) cfg_write(i, pr[i]);
        for (int i = 0; i < 8; i++) begin
            cfg_raddr = 3'(i);
            #1;
            chk("R2", "readback after write", cfg_rdata, pr[i]);
        end
        model_run(pr, exp_done);
        done_seen = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R10", "busy after start", 32'(busy), 32'h1);
        if (poke) begin
            chk("R2", "busy at poke", 32'(busy), 32'h1);
            cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 32'hBAD0_0000;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        while (busy) @(negedge clk);
        while (rs_data.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_done ? "R9" : "R11", "done pulses", 32'(done_seen), exp_done ? 32'h1 : 32'h0);
        chk("R9", "requests left over", 32'(eq_addr.size()), 32'h0);
        for (int i = 0; i < 8; i++) begin
            cfg_raddr = 3'(i);
            #1;
            chk(reg_tag, $sformatf("final reg %0d", i), cfg_rdata, mr[i]);
        end
        foreach (model_mem[k]) chk("R7", $sformatf("mem %h", k), rd(k), model_mem[k]);
        eq_addr.delete(); eq_we.delete(); eq_len.delete(); eq_wd.delete();
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] w[8], input int n);
        for (int i = 0; i < n; i++) mem[base + 32'(4 * i)] = w[i];
    endtask

    initial begin
        logic [31:0] pr[8];
        logic [31:0] w[8];
        for (int a = 32'h1000; a < 32'h1500; a += 4) mem[a] = 32'(a) ^ 32'h5A5A_0000;

        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "busy in reset", 32'(busy), 32'h0);
        chk("R1", "done in reset", 32'(done), 32'h0);
        chk("R1", "mem_req in reset", 32'(mem_req), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            cfg_raddr = 3'(i);
            #1;
            chk("R1", $sformatf("reg %0d after reset", i), cfg_rdata, 32'h0);
        end

        // R3: direct copy, link zero
        pr = '{32'h0, 32'h1000, 32'h2000, 32'd3, 32'd4, 32'd4, 32'h0, 32'h0};
        run("R3", pr, 32'h0, 1'b0);

        // R4, R8, R9: three full descriptors, negative step, zero-count tail
        w = '{32'h480, 32'h1100, 32'h2100, 32'd2, 32'd4, 32'd4, 32'h0, 32'hF0};
        put_desc(32'h400, w, 8);
        w = '{32'h500, 32'h1208, 32'h2200, 32'd3, 32'hFFFF_FFFC, 32'd8, 32'h0, 32'hA0};
        put_desc(32'h480, w, 8);
        w = '{32'h0, 32'h1300, 32'h2300, 32'd0, 32'd4, 32'd4, 32'h0, 32'h0005_5500};
        put_desc(32'h500, w, 8);
        pr = '{32'h400, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
        run("R4", pr, 32'h0, 1'b0);

        // R5: compact chain, junk in unused descriptor words
        w = '{32'h680, 32'h1300, 32'h2300, 32'd2, 32'hDEAD_0004, 32'hDEAD_0005, 32'hDEAD_0006, 32'hDEAD_0007};
        put_desc(32'h600, w, 8);
        w = '{32'h0, 32'h1340, 32'h2340, 32'd1, 32'hDEAD_1004, 32'hDEAD_1005, 32'hDEAD_1006, 32'hDEAD_1007};
        put_desc(32'h680, w, 8);
        pr = '{32'h600, 32'h0, 32'h0, 32'h0, 32'd4, 32'd4, 32'h1, 32'h30};
        run("R5", pr, 32'h0, 1'b0);

        // R6: boundary splits 4+4, 2+6, then a compact 1+3 after a mode change
        w = '{32'h978, 32'h1480, 32'h2480, 32'd1, 32'd4, 32'd4, 32'h0, 32'h10};
        put_desc(32'h870, w, 8);
        w = '{32'hA7C, 32'h1490, 32'h2490, 32'd1, 32'd4, 32'd4, 32'h1, 32'h20};
        put_desc(32'h978, w, 8);
        w = '{32'h0, 32'h14A0, 32'h24A0, 32'd2, 32'h0, 32'h0, 32'h0, 32'h0};
        put_desc(32'hA7C, w, 4);
        pr = '{32'h870, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
        run("R6", pr, 32'h0, 1'b0);

        // R11: error on the second data read; chain must not be followed
        w = '{32'hB80, 32'h1400, 32'h2400, 32'd3, 32'd4, 32'd4, 32'h0, 32'h40};
        put_desc(32'hB00, w, 8);
        w = '{32'h0, 32'h1410, 32'h2410, 32'd1, 32'd4, 32'd4, 32'h0, 32'h0};
        put_desc(32'hB80, w, 8);
        pr = '{32'hB00, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
        run("R11", pr, 32'h1404, 1'b0);

        // R11: error on the third beat of a descriptor fetch
        w = '{32'hC80, 32'h1420, 32'h2420, 32'd1, 32'd4, 32'd4, 32'h0, 32'h0};
        put_desc(32'hC00, w, 8);
        pr = '{32'hC00, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
        run("R11", pr, 32'hC08, 1'b0);

        // R2: config write during a run is ignored
        pr = '{32'h0, 32'h1000, 32'h2600, 32'd4, 32'd4, 32'd4, 32'h0, 32'h0};
        run("R2", pr, 32'h0, 1'b1);

        // R8: direct start with zero count makes no request
        pr = '{32'h0, 32'h1000, 32'h2700, 32'd0, 32'd4, 32'd4, 32'h0, 32'h0};
        run("R8", pr, 32'h0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule